// File: doc/BRIEF.md
# Re-reference Interval Replacement for One Cache Set

This block holds the replacement state of a single set in an N-way set-associative cache. Each way owns a small saturating counter that predicts how far away its next reuse is. A low value means soon and a high value means distant. The counter width is a parameter. With a width of one, the block behaves as a classic not-recently-used scheme.

Requests arrive on a valid/ready stream and come in two kinds. A hit names a way, and that way's counter is cleared. A miss asks the block to pick a victim. The victim is the lowest-numbered way whose counter sits at the maximum. If no way is there, every counter in the set is raised by one per cycle until some way reaches the maximum. The chosen way is then refilled with a near-eviction insertion value and returned on a response stream.

The request side stalls (req_ready low) from the moment a miss is taken until its response has been consumed. The response side holds rsp_valid and rsp_way steady for as long as rsp_ready stays low. Tag storage, data storage and any choice between insertion policies belong to the surrounding cache.

Top module: `rrip_set_repl`

## Requirements
- R1: After reset every counter holds the maximum value, req_ready is high and rsp_valid is low. The first misses after reset are therefore answered one cycle after acceptance, returning ways 0, 1, 2, ... in order.
- R2: An accepted hit (req_miss = 0) sets the named way's counter to 0. That way is not chosen as victim until aging has brought it back to the maximum.
- R3: The way chosen on a miss is loaded with the insertion value, which is maximum minus one (6 for 3-bit counters). For 1-bit counters the insertion value is 0.
- R4: The victim is the lowest-index way whose counter equals the maximum (2^CTR_W − 1).
- R5: While no counter is at the maximum, all counters rise together by one per cycle. A miss response therefore becomes valid 1 + (maximum − largest counter) cycles after the miss is accepted.
- R6: Once rsp_valid is high, it and rsp_way stay unchanged until rsp_ready is seen high at a clock edge. In the cycle after that handshake, rsp_valid is low and req_ready is high.
- R7: req_ready is high only when no miss is in progress. It drops in the cycle after a miss is accepted and stays low until R6's handshake. A request offered while req_ready is low is not taken.
- R8: req_way is ignored for misses; the victim depends only on counter state.
- R9: With 1-bit counters, the block finds all bits at zero on a miss. It sets them all back to one in a single step and then picks way 0 unless a way has been refilled since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_miss | input | 1 | 1 = miss (choose and refill a victim), 0 = hit |
| req_way | input | $clog2(WAYS) | Way touched by a hit; ignored on a miss |
| rsp_valid | output | 1 | Victim way is presented |
| rsp_ready | input | 1 | Consumer takes the victim this cycle |
| rsp_way | output | $clog2(WAYS) | Victim way chosen for the miss |

## Verification
The bench targets the aging path at both extremes. The first case is a set where every counter was just cleared, which needs the full number of increments. The second is a set right after reset, which needs none. A design that aged one step too few or too many would return the wrong way or answer in the wrong cycle. Tie-breaking is swept over every pattern of recently hit ways, because a scan from the top would pick the highest tied way instead of the lowest. Long response stalls are used to catch a victim that drifts or a request side that reopens too early. The same sequences run on a 1-bit instance, where a wrong insertion value would make freshly filled ways look immediately evictable.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_RESP   = 2'd2
  } rrip_state_e;

  // Insertion value: one below the ceiling, or zero when counters are a single bit.
  function automatic int rrip_insert_val(input int cw);
    return (cw == 1) ? 0 : ((1 << cw) - 2);
  endfunction

endpackage

// File: rtl/rrip_ctr_bank.sv
module rrip_ctr_bank #(
  parameter int WAYS  = 4,
  parameter int CTR_W = 3,
  parameter int INS   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hit_en,
  input  logic [$clog2(WAYS)-1:0]  hit_way,
  input  logic                     fill_en,
  input  logic [$clog2(WAYS)-1:0]  fill_way,
  input  logic                     age_en,
  output logic [WAYS*CTR_W-1:0]    ctr_flat
);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [CTR_W-1:0] CEIL = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] INS_V = CTR_W'(INS);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [CTR_W-1:0] ctr_q;
    logic             sel_hit;
    logic             sel_fill;

    assign sel_hit  = hit_en  && (hit_way  == WAY_W'(g));
    assign sel_fill = fill_en && (fill_way == WAY_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctr_q <= CEIL;
      end else if (sel_hit) begin
        ctr_q <= '0;
      end else if (sel_fill) begin
        ctr_q <= INS_V;
      end else if (age_en) begin
        ctr_q <= ctr_q + CTR_W'(1);
      end
    end

    assign ctr_flat[g*CTR_W +: CTR_W] = ctr_q;
  end

endmodule

// File: rtl/rrip_victim_sel.sv
module rrip_victim_sel #(
  parameter int WAYS  = 4,
  parameter int CTR_W = 3
) (
  input  logic [WAYS*CTR_W-1:0]   ctr_flat,
  output logic                    found,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [CTR_W-1:0] CEIL = {CTR_W{1'b1}};

  logic [WAYS-1:0] at_ceil;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign at_ceil[g] = (ctr_flat[g*CTR_W +: CTR_W] == CEIL);
  end

  // Scan downward so the lowest set index is the last one written.
  always_comb begin
    found  = |at_ceil;
    victim = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (at_ceil[i]) victim = WAY_W'(i);
    end
  end

endmodule

// File: rtl/rrip_ctl.sv
module rrip_ctl
  import rrip_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_miss,
  input  logic [$clog2(WAYS)-1:0] req_way,
  output logic                    req_ready,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [$clog2(WAYS)-1:0] rsp_way,
  input  logic                    found,
  input  logic [$clog2(WAYS)-1:0] victim,
  output logic                    hit_en,
  output logic [$clog2(WAYS)-1:0] hit_way,
  output logic                    fill_en,
  output logic [$clog2(WAYS)-1:0] fill_way,
  output logic                    age_en
);
  localparam int WAY_W = $clog2(WAYS);

  rrip_state_e      state_q, state_d;
  logic [WAY_W-1:0] way_q;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_way   = way_q;

  assign hit_en   = req_ready && req_valid && !req_miss;
  assign hit_way  = req_way;
  assign fill_en  = (state_q == ST_SEARCH) && found;
  assign fill_way = victim;
  assign age_en   = (state_q == ST_SEARCH) && !found;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid && req_miss) state_d = ST_SEARCH;
      ST_SEARCH: if (found) state_d = ST_RESP;
      ST_RESP:   if (rsp_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      way_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fill_en) way_q <= victim;
    end
  end

endmodule

// File: rtl/rrip_set_repl.sv
module rrip_set_repl #(
  parameter int WAYS  = 4,
  parameter int CTR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_miss,
  input  logic [$clog2(WAYS)-1:0] req_way,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [$clog2(WAYS)-1:0] rsp_way
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int INS   = rrip_pkg::rrip_insert_val(CTR_W);

  logic                   hit_en, fill_en, age_en, found;
  logic [WAY_W-1:0]       hit_way, fill_way, victim;
  logic [WAYS*CTR_W-1:0]  ctr_flat;

  rrip_ctl #(.WAYS(WAYS)) ctl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_miss(req_miss), .req_way(req_way),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_way(rsp_way),
    .found(found), .victim(victim),
    .hit_en(hit_en), .hit_way(hit_way),
    .fill_en(fill_en), .fill_way(fill_way),
    .age_en(age_en)
  );

  rrip_ctr_bank #(.WAYS(WAYS), .CTR_W(CTR_W), .INS(INS)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .hit_en(hit_en), .hit_way(hit_way),
    .fill_en(fill_en), .fill_way(fill_way),
    .age_en(age_en),
    .ctr_flat(ctr_flat)
  );

  rrip_victim_sel #(.WAYS(WAYS), .CTR_W(CTR_W)) sel_i (
    .ctr_flat(ctr_flat),
    .found(found),
    .victim(victim)
  );

endmodule

// File: rtl/rrip_set_repl_chk.sv
module rrip_set_repl_chk #(
  parameter int WAYS  = 4,
  parameter int CTR_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_miss,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [$clog2(WAYS)-1:0] rsp_way
);
  localparam int LAT_MAX = (1 << CTR_W);

  int busy_q;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 0;
    else if (!req_ready && !rsp_valid) busy_q <= busy_q + 1;
    else busy_q <= 0;
  end

  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_way)));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

  a_r7_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_miss) |=> (!req_ready && !rsp_valid));

  a_r5_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q <= LAT_MAX);

  a_r7_hit_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_miss) |=> (req_ready && !rsp_valid));

endmodule

bind rrip_set_repl rrip_set_repl_chk #(.WAYS(WAYS), .CTR_W(CTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_miss(req_miss),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_way(rsp_way)
);

// File: tb/rrip_set_repl_tb_top.sv
module rrip_harness #(
  parameter int CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_run,
  output int   n_bad,
  output logic done
);
  localparam int W    = 4;
  localparam int MAXV = (1 << CW) - 1;
  localparam int INSV = (CW == 1) ? 0 : MAXV - 1;

  logic       req_valid, req_ready, req_miss, rsp_valid, rsp_ready;
  logic [1:0] req_way, rsp_way;
  int         mdl [W];
  logic [15:0] lfsr;

  rrip_set_repl #(.WAYS(W), .CTR_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_miss(req_miss), .req_way(req_way),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_way(rsp_way)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (CW=%0d) actual=%0d expected=%0d", tag, CW, act, exp);
    end
  endtask

  task automatic do_hit(input int w);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready before hit", int'(req_ready), 1);
    req_valid = 1'b1; req_miss = 1'b0; req_way = 2'(w);
    @(negedge clk);
    req_valid = 1'b0;
    mdl[w] = 0;
  endtask

  task automatic do_miss(input int junk, input int hold, input string tag);
    int top, steps, vic, lat;
    top = 0;
    for (int i = 0; i < W; i++) if (mdl[i] > top) top = mdl[i];
    steps = MAXV - top;
    for (int i = 0; i < W; i++) mdl[i] += steps;
    vic = -1;
    for (int i = 0; i < W; i++) if (vic < 0 && mdl[i] == MAXV) vic = i;
    mdl[vic] = INSV;
    lat = 1 + steps;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready before miss", int'(req_ready), 1);
    req_valid = 1'b1; req_miss = 1'b1; req_way = 2'(junk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rsp_valid && !req_ready, "R7 busy after miss", int'(req_ready), 0);
    for (int n = 1; n < lat; n++) begin
      @(negedge clk);
      chk(!rsp_valid, "R5 still aging", int'(rsp_valid), 0);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R5 response cycle", int'(rsp_valid), 1);
    chk(int'(rsp_way) == vic, {tag, " R4 R8 victim"}, int'(rsp_way), vic);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && int'(rsp_way) == vic, "R6 stall hold",
          int'(rsp_way), vic);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R6 release", int'(req_ready), 1);
  endtask

  initial begin
    n_run = 0; n_bad = 0; done = 1'b0;
    req_valid = 1'b0; req_miss = 1'b0; req_way = '0; rsp_ready = 1'b0;
    lfsr = 16'hACE1;
    for (int i = 0; i < W; i++) mdl[i] = MAXV;
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 reset state", int'(rsp_valid), 0);
    // R1: ways drained in order straight after reset
    for (int i = 0; i < W; i++) do_miss(3 - i, i, "R1");
    // R3 / R9: all ways hold the insertion value now
    do_miss(2, 1, "R3 R9");
    // R2: every pattern of recently hit ways
    for (int m = 0; m < (1 << W); m++) begin
      for (int w = 0; w < W; w++) if (m[w]) do_hit(w);
      do_miss(m % W, m % 3, "R2");
    end
    // R5: long mixed sequence
    for (int k = 0; k < 250; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0] && lfsr[1]) do_miss(int'(lfsr[5:4]), int'(lfsr[7:6]) % 3, "R5");
      else do_hit(int'(lfsr[3:2]));
    end
    done = 1'b1;
  end

endmodule

module rrip_set_repl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   r3, b3, r1, b1, cyc, runs, fails;
  logic d3, d1;

  always #10 clk = ~clk;

  rrip_harness #(.CW(3)) h3_i (.clk(clk), .rst_n(rst_n), .n_run(r3), .n_bad(b3), .done(d3));
  rrip_harness #(.CW(1)) h1_i (.clk(clk), .rst_n(rst_n), .n_run(r1), .n_bad(b1), .done(d1));

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!(d3 === 1'b1 && d1 === 1'b1) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    runs  = r3 + r1;
    fails = b3 + b1;
    if (!(d3 === 1'b1 && d1 === 1'b1)) begin
      runs++;
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d expected=%0d", cyc, 150000);
    end
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule